// File: doc/BRIEF.md
# Fully Associative Read Cache with FIFO Replacement

This block is a small read-only cache that sits between a single requester and a slower backing memory. Any memory block may live in any entry. A word address is split into a block tag (the upper bits) and a word offset (the low bits). There is no set index. The tag is compared against every stored entry in the same cycle. When an entry matches, the requested word comes back on the cycle after the request is taken.

When no entry matches, the cache stops taking requests and asks the backing memory for the whole block through a ready/valid request port. It waits for the block on the response port and writes it into an entry. In the same cycle it forwards the requested word to the requester, and it then accepts requests again. A circular insertion pointer picks the entry to replace. The pointer moves only when a block is installed, so hits have no influence on which entry is replaced next.

The entry count, the words per block, the word width and the address width are parameters.

Top module: `fac_cache`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The first reference to any block after reset is a miss. It issues exactly one backing request whose `mem_req_addr` equals `req_addr` with the offset bits removed.
- R3: A request that hits raises `rsp_valid` for one cycle on the cycle after acceptance. `rsp_data` holds the word selected by the low `log2(WORDS)` address bits, and no backing request is made.
- R4: During a miss, `req_ready` stays 0 until the response. `mem_req_valid` stays 1 and `mem_req_addr` stays stable until `mem_req_ready` is seen.
- R5: When `mem_rsp_valid` arrives for an outstanding miss, the block is installed. On the next cycle `rsp_valid` is 1 with word `k` taken from bits `[k*WORD_W +: WORD_W]` of the returned block, and `req_ready` is 1 again.
- R6: When all entries are valid, a miss replaces the entry that was installed earliest among those present.
- R7: The insertion pointer advances only on an install. Hits on the oldest entry do not protect it from replacement.
- R8: Invalid entries are filled in ascending index order before any valid entry is replaced. After ENTRIES distinct blocks are loaded, all of them hit.
- R9: At most one entry matches any lookup tag.
- R10: Addresses that differ only in offset bits share one block and hit each other. Addresses that differ in any tag bit are distinct blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can take a request this cycle |
| req_addr | input | ADDR_W (12) | Word address of the read |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_data | output | WORD_W (32) | Read data word |
| mem_req_valid | output | 1 | Block fetch request to backing memory |
| mem_req_ready | input | 1 | Backing memory takes the fetch |
| mem_req_addr | output | ADDR_W-log2(WORDS) (10) | Block address to fetch |
| mem_rsp_valid | input | 1 | Fetched block present |
| mem_rsp_data | input | WORDS*WORD_W (128) | Fetched block, word 0 in the low bits |

## Verification
When a fetched block returns, two things happen in the same cycle. The block is written into the victim entry, and its requested word is forwarded to the requester. The request interface then reopens on the very next edge. The bench provokes this by issuing the next request immediately after each miss, often to the block that was just installed. It judges the result by comparing the forwarded word and then checking that the follow-up lookup hits without a second backing request. Back-to-back hits also overlap one response with the next lookup, and the scoreboard checks the order of those responses.

// File: rtl/fac_pkg.sv
package fac_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ASK  = 2'd1,
      ST_WAIT = 2'd2
   } fill_state_t;

endpackage

// File: rtl/fac_tag_match.sv
module fac_tag_match #(
   parameter int ENTRIES = 4,
   parameter int TAG_W   = 10,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [TAG_W-1:0]   lookup_tag,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [TAG_W-1:0]   wr_tag,
   output logic [ENTRIES-1:0] valid_o,
   output logic               hit_o,
   output logic [IDX_W-1:0]   hit_idx_o
);

   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] match;

   // one comparator and one storage slot per entry
   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign match[e] = valid_q[e] && (tag_q[e] == lookup_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
            tag_q[e]   <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            valid_q[e] <= 1'b1;
            tag_q[e]   <= wr_tag;
         end
      end
   end

   always_comb begin
      hit_idx_o = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match[e]) hit_idx_o = hit_idx_o | IDX_W'(e);
      end
   end

   assign hit_o   = |match;
   assign valid_o = valid_q;

   p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match))
      else $error("R9: more than one entry matches");

endmodule

// File: rtl/fac_fifo_victim.sv
module fac_fifo_victim #(
   parameter int ENTRIES = 4,
   parameter int IDX_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               advance,
   input  logic [ENTRIES-1:0] valid_i,
   output logic [IDX_W-1:0]   victim_o
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (advance) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   assign victim_o = ptr_q;

   // checker: entries below the pointer must all be valid
   logic [ENTRIES-1:0] below_mask;
   always_comb begin
      below_mask = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (IDX_W'(e) < ptr_q) below_mask[e] = 1'b1;
      end
   end

   p_fill_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(&valid_i) |-> (!valid_i[ptr_q] && ((valid_i & below_mask) == below_mask)))
      else $error("R8: victim is not the lowest invalid entry");

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(ptr_q))
      else $error("R7: pointer moved without an install");

endmodule

// File: rtl/fac_cache.sv
module fac_cache #(
   parameter int ENTRIES = 4,
   parameter int WORDS   = 4,
   parameter int WORD_W  = 32,
   parameter int ADDR_W  = 12
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   req_valid,
   output logic                                   req_ready,
   input  logic [ADDR_W-1:0]                      req_addr,
   output logic                                   rsp_valid,
   output logic [WORD_W-1:0]                      rsp_data,
   output logic                                   mem_req_valid,
   input  logic                                   mem_req_ready,
   output logic [ADDR_W-$clog2(WORDS)-1:0]        mem_req_addr,
   input  logic                                   mem_rsp_valid,
   input  logic [WORDS*WORD_W-1:0]                mem_rsp_data
);
   import fac_pkg::*;

   localparam int OFF_W   = $clog2(WORDS);
   localparam int OFF_S   = (OFF_W > 0) ? OFF_W : 1;
   localparam int TAG_W   = ADDR_W - OFF_W;
   localparam int IDX_W   = $clog2(ENTRIES);
   localparam int BLOCK_W = WORDS * WORD_W;

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (WORDS == (1 << OFF_W)) else $error("WORDS must be a power of two");
      assert (TAG_W >= 1) else $error("ADDR_W too small for block size");
   end

   fill_state_t       state_q;
   logic [TAG_W-1:0]  req_tag, miss_tag_q;
   logic [OFF_S-1:0]  req_off, miss_off_q;

   // address split: variant without offset bits when a block is one word
   if (OFF_W > 0) begin : g_split
      assign req_tag = req_addr[ADDR_W-1:OFF_W];
      assign req_off = req_addr[OFF_S-1:0];
   end else begin : g_nosplit
      assign req_tag = req_addr;
      assign req_off = '0;
   end

   logic               hit;
   logic [IDX_W-1:0]   hit_idx, victim;
   logic [ENTRIES-1:0] valid_vec;
   logic               accept, install;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign install   = (state_q == ST_WAIT) && mem_rsp_valid;

   fac_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .lookup_tag (req_tag),
      .wr_en      (install),
      .wr_idx     (victim),
      .wr_tag     (miss_tag_q),
      .valid_o    (valid_vec),
      .hit_o      (hit),
      .hit_idx_o  (hit_idx)
   );

   fac_fifo_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .advance  (install),
      .valid_i  (valid_vec),
      .victim_o (victim)
   );

   logic [BLOCK_W-1:0] data_q [ENTRIES];
   logic [BLOCK_W-1:0] hit_block;
   logic [WORD_W-1:0]  hit_word, fill_word;

   always_ff @(posedge clk) begin
      if (install) data_q[victim] <= mem_rsp_data;
   end

   assign hit_block = data_q[hit_idx];
   assign hit_word  = hit_block[int'(req_off)*WORD_W +: WORD_W];
   assign fill_word = mem_rsp_data[int'(miss_off_q)*WORD_W +: WORD_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         miss_tag_q <= '0;
         miss_off_q <= '0;
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
      end else begin
         rsp_valid <= (accept && hit) || install;
         if (install)            rsp_data <= fill_word;
         else if (accept && hit) rsp_data <= hit_word;
         case (state_q)
            ST_IDLE: if (accept && !hit) begin
               miss_tag_q <= req_tag;
               miss_off_q <= req_off;
               state_q    <= ST_ASK;
            end
            ST_ASK:  if (mem_req_ready) state_q <= ST_WAIT;
            ST_WAIT: if (mem_rsp_valid) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_valid = (state_q == ST_ASK);
   assign mem_req_addr  = miss_tag_q;

   p_hit_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit) |=> (rsp_valid && !mem_req_valid))
      else $error("R3: hit did not respond next cycle");

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
      else $error("R4: fetch request dropped or changed");

   p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready)
      else $error("R4: request accepted during a miss");

   p_fill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rsp_valid && (state_q == ST_WAIT)) |=> (rsp_valid && req_ready))
      else $error("R5: fill did not forward data");

endmodule

// File: tb/test_fac_cache.sv
`timescale 1ns/1ps
module test_fac_cache;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [11:0]  req_addr = '0;
   logic         rsp_valid;
   logic [31:0]  rsp_data;
   logic         mem_req_valid;
   logic         mem_req_ready = 1'b0;
   logic [9:0]   mem_req_addr;
   logic         mem_rsp_valid = 1'b0;
   logic [127:0] mem_rsp_data = '0;

   always #2.5 clk = ~clk;

   fac_cache i_fac_cache (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
   );

   typedef struct {
      logic [31:0] data;
      bit          miss;
      int          cnt;
      logic [9:0]  blk;
      string       req;
   } item_t;

   item_t       sb[$];
   int          checks = 0, errors = 0;
   int          mem_cnt = 0;
   logic [9:0]  last_blk = '0;
   int          stall_err = 0;
   bit          done = 1'b0;

   function automatic logic [31:0] word_of(input logic [9:0] b, input int w);
      return 32'hC0DE_0000 | (32'(b) << 4) | 32'(w);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // backing memory model with varying latency
   always @(posedge clk) begin
      if (mem_req_valid && mem_req_ready) begin
         mem_cnt  <= mem_cnt + 1;
         last_blk <= mem_req_addr;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [9:0] b;
            repeat (mem_cnt % 3) @(negedge clk);
            b = mem_req_addr;
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (1 + (mem_cnt % 2)) @(negedge clk);
            for (int w = 0; w < 4; w++) mem_rsp_data[w*32 +: 32] = word_of(b, w);
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
         end
      end
   end

   // stall monitor (R4)
   always @(negedge clk) if (rst_n && mem_req_valid && req_ready) stall_err++;

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R3", "unexpected response", rsp_data, 32'h0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(rsp_data == it.data, it.req, "data", rsp_data, it.data);
            check((mem_cnt - it.cnt) == int'(it.miss), it.req, "fetch count",
                  32'(mem_cnt - it.cnt), 32'(it.miss));
            if (it.miss)
               check(last_blk == it.blk, "R2", "fetch block address",
                     32'(last_blk), 32'(it.blk));
         end
      end
   end

   // driver: push the expected item once the request is taken
   task automatic rd(input logic [9:0] blk, input int w, input bit miss, input string req);
      item_t it;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = {blk, 2'(w)};
      while (!req_ready) @(negedge clk);
      it.data = word_of(blk, w);
      it.miss = miss;
      it.cnt  = mem_cnt;
      it.blk  = blk;
      it.req  = req;
      sb.push_back(it);
      @(posedge clk);
   endtask

   localparam logic [9:0] BA = 10'h005, BB = 10'h009, BC = 10'h03F,
                          BD = 10'h100, BE = 10'h2AA, BF = 10'h205;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
      check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'h0);

      // cold fills in order (R2, R8), offset sharing (R10)
      rd(BA, 0, 1, "R2");
      rd(BA, 3, 0, "R10");
      rd(BB, 1, 1, "R5");
      rd(BB, 2, 0, "R5");
      rd(BC, 2, 1, "R2");
      rd(BD, 0, 1, "R2");
      // all four resident, back-to-back hits (R3, R8)
      rd(BA, 1, 0, "R8");
      rd(BB, 3, 0, "R8");
      rd(BC, 0, 0, "R8");
      rd(BD, 2, 0, "R3");
      // hits on the oldest do not protect it (R7)
      rd(BA, 2, 0, "R7");
      rd(BA, 0, 0, "R7");
      rd(BE, 1, 1, "R6");
      rd(BB, 0, 0, "R6");
      rd(BC, 1, 0, "R6");
      rd(BD, 3, 0, "R6");
      rd(BE, 3, 0, "R5");
      rd(BA, 1, 1, "R7");
      // each new miss takes the next oldest (R6)
      rd(BB, 2, 1, "R6");
      rd(BC, 3, 1, "R6");
      rd(BD, 1, 1, "R6");
      rd(BA, 0, 0, "R6");
      rd(BB, 1, 0, "R6");
      rd(BC, 2, 0, "R6");
      rd(BE, 0, 1, "R6");
      // one tag bit differs from BA (R10)
      rd(BF, 2, 1, "R10");
      rd(BF, 1, 0, "R10");
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      check(sb.size() == 0, "R5", "responses outstanding", 32'(sb.size()), 32'h0);
      check(stall_err == 0, "R4", "req_ready high during miss", 32'(stall_err), 32'h0);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         summary();
      end
   end

endmodule